// File: doc/BRIEF.md
# Scratchpad Address and Transfer-Status Tracker

This block sits between a byte-serial bus layer and a 32-byte write scratchpad. The bus layer loads a 16-bit target address, one byte per strobe. The low byte supplies the scratchpad offset at which buffering begins. Data then arrives one bit per strobe, least significant bit first. Each completed byte is written to the scratchpad at the current offset, and the offset advances until the last slot, 1Fh, has been filled. Bytes that arrive after that are dropped.

When the bus layer signals the end of the transfer, the block latches a status byte. This byte holds three things:
- the offset of the last byte written,
- a flag for a trailing partial byte,
- a flag that is set once a copy has been accepted.

A copy into the nonvolatile array is permitted only when the last written offset is 1Fh. A small read filter on the memory read path forces bytes in the password address window to 00h.

The control is a four-state machine:
- ST_IDLE: waiting for the address to be armed.
- ST_RECV: receiving bytes into the scratchpad.
- ST_FULL: slot 1Fh has been written; further bytes are discarded.
- ST_ENDED: the transfer has finished; copy requests are evaluated here.

Transitions:
- IDLE→RECV on a high-byte load.
- Any state→IDLE on a low-byte load alone.
- Any state→RECV on a high-byte load.
- RECV→FULL when the byte for offset 1Fh is written.
- RECV→ENDED and FULL→ENDED on the end strobe.
- ENDED stays put until the next address load.

Address loads take priority over every other input in the same cycle.

Top module: `sp_addr_tracker`

## Requirements
- R1: `addr_lo_we` loads `addr_byte` into `tgt_addr[7:0]`, and `addr_hi_we` loads it into `tgt_addr[15:8]`. A high-byte load arms reception (ST_RECV).
- R2: Serial bits are assembled least significant bit first. The first complete byte after arming is written (`sp_we` high for one cycle) at offset `tgt_addr[4:0]`, in the cycle after its eighth bit strobe.
- R3: Each further byte is written at the next offset. Status bits 4..0 hold the offset of the last byte written, updated one cycle after the write.
- R4: Once offset 1Fh has been written, later bytes produce no write and status bits 4..0 stay 1Fh.
- R5: On `xfer_end` in ST_RECV or ST_FULL, status bit 5 is set if the number of bits received since arming is not a multiple of 8, and cleared otherwise.
- R6: The status layout is {bit7 copy-done, bit6 constant 0, bit5 partial flag, bits4..0 ending offset}. It is all zero after reset.
- R7: Any address-byte load clears status bits 7, 5 and 4..0 in the next cycle.
- R8: `copy_ok` is high only in ST_ENDED with ending offset 1Fh. A `copy_req` while `copy_ok` is high sets status bit 7.
- R9: A `copy_req` while `copy_ok` is low leaves the status unchanged.
- R10: `rd_data` is 00h when `rd_addr` lies in [PW_FIRST, PW_LAST] (defaults 0200h..021Fh). Otherwise it equals `rd_raw`.
- R11: Bit strobes and `xfer_end` have no effect in ST_IDLE and ST_ENDED: no scratchpad write and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_byte | input | 8 | Address byte to load |
| addr_lo_we | input | 1 | Load low target-address byte |
| addr_hi_we | input | 1 | Load high target-address byte and arm |
| bit_valid | input | 1 | Serial data bit strobe |
| bit_data | input | 1 | Serial data bit |
| xfer_end | input | 1 | End-of-transfer strobe |
| copy_req | input | 1 | Copy request |
| rd_addr | input | 16 | Memory read address |
| rd_raw | input | 8 | Raw byte read from memory |
| rd_data | output | 8 | Filtered read byte |
| tgt_addr | output | 16 | Target address readback |
| status | output | 8 | Transfer status byte (read-only) |
| sp_we | output | 1 | Scratchpad write enable |
| sp_waddr | output | 5 | Scratchpad write offset |
| sp_wdata | output | 8 | Scratchpad write data |
| copy_ok | output | 1 | Copy permitted |

## Verification
Several transfer patterns are used to exercise the main function.

- A start at 13Ch fills only four slots and then receives a surplus byte. This separates correct wrap-free saturation at 1Fh from a pointer that rolls over or keeps writing.
- A start at offset 10h that ends after two bytes plus three bits exercises two things. It shows that the partial flag tracks the bit count rather than the byte count, and that a short transfer refuses the copy without disturbing the status.
- A low-byte-only load followed by data, and data sent after the end strobe, show that bits are dropped when the machine is not armed.
- A single byte at 1Fh shows that a one-byte transfer can legally enable the copy.

// File: rtl/sp_trk_pkg.sv
package sp_trk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RECV  = 2'd1,
        ST_FULL  = 2'd2,
        ST_ENDED = 2'd3
    } trk_state_t;
endpackage

// File: rtl/sp_bit_deser.sv
module sp_bit_deser #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              bit_valid,
    input  logic              bit_data,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_q,
    output logic              partial
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shnext;

    // least significant bit arrives first, so shift toward bit 0
    assign shnext  = {bit_data, shreg[BYTE_W-1:1]};
    assign partial = (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            shreg    <= '0;
            byte_q   <= '0;
            byte_stb <= 1'b0;
        end else if (clr) begin
            cnt      <= '0;
            byte_stb <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            if (en && bit_valid) begin
                shreg <= shnext;
                if (cnt == CNT_TOP) begin
                    cnt      <= '0;
                    byte_q   <= shnext;
                    byte_stb <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sp_rd_mask.sv
module sp_rd_mask #(
    parameter int              AW       = 16,
    parameter int              DW       = 8,
    parameter logic [AW-1:0]   PW_FIRST = 16'h0200,
    parameter logic [AW-1:0]   PW_LAST  = 16'h021F
) (
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_raw,
    output logic [DW-1:0] rd_data
);
    logic hidden;

    always_comb begin
        hidden  = (rd_addr >= PW_FIRST) && (rd_addr <= PW_LAST);
        rd_data = hidden ? '0 : rd_raw;
    end
endmodule

// File: rtl/sp_addr_tracker.sv
module sp_addr_tracker
    import sp_trk_pkg::*;
#(
    parameter int                  ADDR_W   = 16,
    parameter int                  SP_DEPTH = 32,
    parameter int                  DW       = 8,
    parameter logic [ADDR_W-1:0]   PW_FIRST = 16'h0200,
    parameter logic [ADDR_W-1:0]   PW_LAST  = 16'h021F,
    localparam int                 HALF_W   = ADDR_W / 2,
    localparam int                 OFS_W    = $clog2(SP_DEPTH),
    localparam int                 ST_W     = OFS_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] addr_byte,
    input  logic              addr_lo_we,
    input  logic              addr_hi_we,
    input  logic              bit_valid,
    input  logic              bit_data,
    input  logic              xfer_end,
    input  logic              copy_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DW-1:0]     rd_raw,
    output logic [DW-1:0]     rd_data,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [ST_W-1:0]   status,
    output logic              sp_we,
    output logic [OFS_W-1:0]  sp_waddr,
    output logic [DW-1:0]     sp_wdata,
    output logic              copy_ok
);
    localparam logic [OFS_W-1:0] LAST_OFS = '1;

    trk_state_t       st, st_nxt;
    logic [OFS_W-1:0] wptr;
    logic [OFS_W-1:0] end_ofs;
    logic             pf_q;
    logic             done_q;
    logic             any_load;
    logic             rx_en;
    logic             byte_stb;
    logic [DW-1:0]    byte_q;
    logic             partial;
    logic             copy_fire;
    logic             ends_now;

    assign any_load = addr_lo_we | addr_hi_we;
    assign rx_en    = ((st == ST_RECV) || (st == ST_FULL)) && !any_load;
    assign ends_now = rx_en && xfer_end;

    sp_bit_deser #(.BYTE_W(DW)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (any_load),
        .en       (rx_en),
        .bit_valid(bit_valid),
        .bit_data (bit_data),
        .byte_stb (byte_stb),
        .byte_q   (byte_q),
        .partial  (partial)
    );

    sp_rd_mask #(
        .AW      (ADDR_W),
        .DW      (DW),
        .PW_FIRST(PW_FIRST),
        .PW_LAST (PW_LAST)
    ) u_mask (
        .rd_addr(rd_addr),
        .rd_raw (rd_raw),
        .rd_data(rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // transitions
    always_comb begin
        st_nxt = st;
        if (addr_hi_we) begin
            st_nxt = ST_RECV;
        end else if (addr_lo_we) begin
            st_nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:  st_nxt = ST_IDLE;
                ST_RECV: begin
                    if (xfer_end)                            st_nxt = ST_ENDED;
                    else if (byte_stb && wptr == LAST_OFS)   st_nxt = ST_FULL;
                end
                ST_FULL:  if (xfer_end) st_nxt = ST_ENDED;
                ST_ENDED: st_nxt = ST_ENDED;
            endcase
        end
    end

    // outputs
    always_comb begin
        sp_we     = (st == ST_RECV) && byte_stb && !any_load;
        sp_waddr  = wptr;
        sp_wdata  = byte_q;
        copy_ok   = (st == ST_ENDED) && (end_ofs == LAST_OFS);
        copy_fire = copy_ok && copy_req && !any_load;
        status    = {done_q, 1'b0, pf_q, end_ofs};
    end

    // address and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_addr <= '0;
            wptr     <= '0;
            end_ofs  <= '0;
            pf_q     <= 1'b0;
            done_q   <= 1'b0;
        end else if (any_load) begin
            if (addr_lo_we) begin
                tgt_addr[HALF_W-1:0] <= addr_byte;
                wptr                 <= addr_byte[OFS_W-1:0];
            end
            if (addr_hi_we) tgt_addr[ADDR_W-1:HALF_W] <= addr_byte;
            end_ofs <= '0;
            pf_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (sp_we) begin
                end_ofs <= wptr;
                if (wptr != LAST_OFS) wptr <= wptr + 1'b1;
            end
            if (ends_now)  pf_q   <= partial;
            if (copy_fire) done_q <= 1'b1;
        end
    end
endmodule

// File: rtl/sp_addr_tracker_chk.sv
module sp_addr_tracker_chk #(
    parameter int              ADDR_W   = 16,
    parameter int              OFS_W    = 5,
    parameter int              DW       = 8,
    parameter logic [ADDR_W-1:0] PW_FIRST = 16'h0200,
    parameter logic [ADDR_W-1:0] PW_LAST  = 16'h021F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_lo_we,
    input logic              addr_hi_we,
    input logic              bit_valid,
    input logic              xfer_end,
    input logic              copy_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DW-1:0]     rd_data,
    input logic [OFS_W+2:0]  status,
    input logic              sp_we,
    input logic [OFS_W-1:0]  sp_waddr,
    input logic              copy_ok
);
    logic ld;
    assign ld = addr_lo_we | addr_hi_we;

    // R3
    end_ofs_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |=> status[OFS_W-1:0] == $past(sp_waddr));

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[OFS_W-1:0] == '1 && !ld) |=> status[OFS_W-1:0] == '1);

    // R7
    load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (status[OFS_W+2] == 1'b0 && status[OFS_W] == 1'b0 && status[OFS_W-1:0] == '0));

    // R8
    copy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_req && copy_ok && !ld) |=> status[OFS_W+2]);

    // R9
    refused_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_req && !copy_ok && !ld && !bit_valid && !xfer_end && !sp_we) |=> $stable(status));

    // R10
    pw_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr >= PW_FIRST && rd_addr <= PW_LAST) |-> rd_data == '0);
endmodule

bind sp_addr_tracker sp_addr_tracker_chk #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .DW(DW), .PW_FIRST(PW_FIRST), .PW_LAST(PW_LAST)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_lo_we(addr_lo_we), .addr_hi_we(addr_hi_we),
    .bit_valid(bit_valid), .xfer_end(xfer_end), .copy_req(copy_req),
    .rd_addr(rd_addr), .rd_data(rd_data), .status(status), .sp_we(sp_we),
    .sp_waddr(sp_waddr), .copy_ok(copy_ok)
);

// File: tb/sp_addr_tracker_test.sv
module sp_addr_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr_byte = '0;
    logic        addr_lo_we = 1'b0, addr_hi_we = 1'b0;
    logic        bit_valid = 1'b0, bit_data = 1'b0;
    logic        xfer_end = 1'b0, copy_req = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [7:0]  rd_raw = '0;
    logic [7:0]  rd_data;
    logic [15:0] tgt_addr;
    logic [7:0]  status;
    logic        sp_we;
    logic [4:0]  sp_waddr;
    logic [7:0]  sp_wdata;
    logic        copy_ok;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sp_addr_tracker uut (
        .clk(clk), .rst_n(rst_n), .addr_byte(addr_byte), .addr_lo_we(addr_lo_we),
        .addr_hi_we(addr_hi_we), .bit_valid(bit_valid), .bit_data(bit_data),
        .xfer_end(xfer_end), .copy_req(copy_req), .rd_addr(rd_addr), .rd_raw(rd_raw),
        .rd_data(rd_data), .tgt_addr(tgt_addr), .status(status), .sp_we(sp_we),
        .sp_waddr(sp_waddr), .sp_wdata(sp_wdata), .copy_ok(copy_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_addr(input logic [15:0] a);
        addr_byte = a[7:0]; addr_lo_we = 1'b1;
        @(negedge clk);
        addr_lo_we = 1'b0; addr_byte = a[15:8]; addr_hi_we = 1'b1;
        @(negedge clk);
        addr_hi_we = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_we,
                             input logic [4:0] exp_ofs, input string req);
        for (int i = 0; i < 8; i++) begin
            bit_valid = 1'b1; bit_data = b[i];
            @(negedge clk);
        end
        bit_valid = 1'b0;
        chk(req, sp_we, exp_we);
        if (exp_we) begin
            chk(req, sp_waddr, exp_ofs);
            chk(req, sp_wdata, b);
        end
        @(negedge clk);
    endtask

    task automatic send_bits(input int n);
        for (int i = 0; i < n; i++) begin
            bit_valid = 1'b1; bit_data = i[0];
            @(negedge clk);
        end
        bit_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic end_xfer();
        xfer_end = 1'b1;
        @(negedge clk);
        xfer_end = 1'b0;
    endtask

    task automatic do_copy(input bit exp_ok, input string req);
        copy_req = 1'b1;
        chk(req, copy_ok, exp_ok);
        @(negedge clk);
        copy_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R6 reset status", status, 8'h00);
        chk("R6 reset copy_ok", copy_ok, 1'b0);
        chk("R6 reset we", sp_we, 1'b0);
        chk("R1 reset tgt", tgt_addr, 16'h0000);
    endtask

    task automatic t_fill_13c();
        load_addr(16'h013C);
        chk("R1 tgt", tgt_addr, 16'h013C);
        send_byte(8'hA1, 1'b1, 5'h1C, "R2 first byte");
        chk("R3 ofs", status, 8'h1C);
        send_byte(8'hB2, 1'b1, 5'h1D, "R3 second");
        send_byte(8'hC3, 1'b1, 5'h1E, "R3 third");
        chk("R3 ofs", status, 8'h1E);
        send_byte(8'hD4, 1'b1, 5'h1F, "R3 fourth");
        chk("R3 ofs full", status, 8'h1F);
        send_byte(8'hE5, 1'b0, 5'h00, "R4 surplus dropped");
        chk("R4 ofs held", status, 8'h1F);
        end_xfer();
        chk("R6 ended status", status, 8'h1F);
        do_copy(1'b1, "R8 copy allowed");
        chk("R8 done bit", status, 8'h9F);
        send_byte(8'h3C, 1'b0, 5'h00, "R11 bits after end");
        end_xfer();
        chk("R11 status after end", status, 8'h9F);
    endtask

    task automatic t_partial();
        load_addr(16'h0010);
        chk("R7 load clears", status, 8'h00);
        send_byte(8'h5A, 1'b1, 5'h10, "R2 start 10h");
        send_byte(8'hC7, 1'b1, 5'h11, "R3 next 11h");
        send_bits(3);
        end_xfer();
        chk("R5 partial flag", status, 8'h31);
        do_copy(1'b0, "R8 copy refused");
        chk("R9 refused status", status, 8'h31);
    endtask

    task automatic t_idle_ignore();
        addr_byte = 8'h3F; addr_lo_we = 1'b1;
        @(negedge clk);
        addr_lo_we = 1'b0;
        chk("R7 lo load clears", status, 8'h00);
        send_byte(8'h99, 1'b0, 5'h00, "R11 idle bits");
        end_xfer();
        chk("R11 idle status", status, 8'h00);
        addr_byte = 8'h00; addr_hi_we = 1'b1;
        @(negedge clk);
        addr_hi_we = 1'b0;
        send_byte(8'h77, 1'b1, 5'h1F, "R2 single at 1Fh");
        end_xfer();
        chk("R5 whole byte no flag", status, 8'h1F);
        chk("R8 copy_ok one byte", copy_ok, 1'b1);
    endtask

    task automatic t_mask();
        rd_raw = 8'h5A;
        rd_addr = 16'h0200; #1; chk("R10 first pw", rd_data, 8'h00);
        rd_addr = 16'h021F; #1; chk("R10 last pw", rd_data, 8'h00);
        rd_addr = 16'h0220; #1; chk("R10 above", rd_data, 8'h5A);
        rd_addr = 16'h01FF; #1; chk("R10 below", rd_data, 8'h5A);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_13c();
        t_partial();
        t_idle_ignore();
        t_mask();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule